// File: doc/BRIEF.md
# Interleaved Memory Bank Interlock Arbiter

This block stands in front of a row of memory banks that each run their own access cycle. One request can arrive in each bus slot. A request carries a source number and a target bank index. The block answers in the same slot with either a grant or a lockout. A locked-out source must present the request again in a later major cycle, which is eight slots long. Once a bank accepts an access, it stays busy for one full major cycle.

Priority is fixed and has three classes. When a source of the middle or top class is locked out on a bank and is locked out again on its retry, it takes a reservation on that bank. From then on, every other source is turned away from that bank, even when the bank is idle. The reservation ends when its owner is granted. Requests spread across different banks do not interact.

The bank count is the parameter `NBANK`, from 1 to 39. The index port is `BIW` bits wide, and `NBANK` must not exceed 2**BIW.

Top module: `bank_lock_arbiter`

## Requirements
- R1: A bank granted in slot t refuses every request in slots t+1 to t+7 and may be granted again from slot t+8.
- R2: Each valid request whose bank index is below NBANK receives exactly one of grant and lockout in the slot it is presented. A slot with req_valid low receives neither.
- R3: Source numbers map to classes as follows: 0 is the I/O synchronizer (top class), 1 is the processor (middle class), and 2 and 3 are the computers (bottom class).
- R4: A retry is the next locked-out request from the same source to the same bank. When a source of class above bottom makes a retry that is locked out again, it reserves that bank, provided the bank is unreserved.
- R5: While a bank is reserved, a request to it from any other source is locked out, even if the bank is idle.
- R6: The reserving source is granted as soon as the bank is idle. That grant clears the reservation, so other sources may be granted once the bank's busy period ends.
- R7: Computers never reserve a bank. When both computers contend for a bank, the one presenting first is granted and the other is locked out.
- R8: A strictly higher-class source whose retry is locked out takes over a reservation held by a lower class. A source of lower or equal class never takes over a reservation.
- R9: Banks are independent: successive slots may grant different banks regardless of the busy state of the others.
- R10: A request with a bank index at or above NBANK receives neither grant nor lockout and changes no bank's state.
- R11: Reset leaves every bank idle and unreserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one edge per bus slot |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present in this slot |
| req_src | input | 2 | Requesting source number (0 I/O, 1 processor, 2/3 computers) |
| req_bank | input | BIW | Target bank index |
| grant | output | 1 | The request may start its access in this slot |
| lockout | output | 1 | The request is refused and must be retried |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- The exact edge of the busy window, slots t+7 and t+8. A counter loaded one too low would grant early; one loaded one too high would lock out a legal request.
- Reservation at an idle bank. A design that checks only the busy count would hand the bank to a computer while the processor holds the reservation.
- Takeover by the I/O source from the processor, and no takeover in the other direction. A wrong comparison would let the processor starve the I/O source.
- Contention between the two computers. A design that reserved for them would turn away the first computer on its later request.
- Out-of-range indices, including ones that alias a real bank in their low bits. Sloppy decoding would produce a response or mark a bank busy.

A long pseudo-random sweep over four banks compares every response with an arithmetic model. It also confirms from the ports that no bank is granted twice within eight slots.

// File: rtl/bla_pkg.sv
package bla_pkg;

    localparam int SRC_W = 2;
    localparam int NSRC  = 4;
    localparam int CNT_W = 3;

    localparam logic [CNT_W-1:0] BUSY_LOAD = 3'd7;

    typedef logic [1:0] cls_t;

    // R3: source number to priority class (2 top, 0 bottom)
    function automatic cls_t src_class(input logic [SRC_W-1:0] src);
        case (src)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bla_bank.sv
module bla_bank
    import bla_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             retry_i,
    input  logic [SRC_W-1:0] src_i,
    output logic             grant_o,
    output logic             lock_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rv;
        logic [SRC_W-1:0] own;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     owner_hit;
    logic     can_claim;

    always_comb begin
        st_d      = st_q;
        owner_hit = st_q.rv && (st_q.own == src_i);
        grant_o   = sel_i && (st_q.cnt == '0) && (!st_q.rv || owner_hit);
        lock_o    = sel_i && !grant_o;
        can_claim = (src_class(src_i) != 2'd0) &&
                    (!st_q.rv || (src_class(src_i) > src_class(st_q.own)));
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (grant_o) begin
            st_d.cnt = BUSY_LOAD;
            if (owner_hit) begin
                st_d.rv = 1'b0;
            end
        end else if (lock_o && retry_i && can_claim) begin
            st_d.rv  = 1'b1;
            st_d.own = src_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> st_q.cnt == 3'd7);

    p_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 3'd1);

    p_busy_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && st_q.cnt != '0) |-> lock_o);

    p_resv_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && st_q.rv && st_q.own != src_i) |-> !grant_o);

    p_resv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && st_q.rv) |=> !st_q.rv);

    p_no_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && src_class(src_i) == 2'd0 && !st_q.rv) |=> !st_q.rv);

endmodule

// File: rtl/bla_retry.sv
module bla_retry
    import bla_pkg::*;
#(
    parameter int BIW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [BIW-1:0]   bank_i,
    input  logic             grant_i,
    input  logic             lock_i,
    output logic             retry_o
);

    typedef struct packed {
        logic [NSRC-1:0]          pend;
        logic [NSRC-1:0][BIW-1:0] pbank;
    } trk_st_t;

    trk_st_t trk_d, trk_q;

    always_comb begin
        trk_d   = trk_q;
        retry_o = trk_q.pend[src_i] && (trk_q.pbank[src_i] == bank_i);
        if (grant_i) begin
            trk_d.pend[src_i] = 1'b0;
        end else if (lock_i) begin
            trk_d.pend[src_i]  = 1'b1;
            trk_d.pbank[src_i] = bank_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> trk_q.pend != '0);

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_i && lock_i));

endmodule

// File: rtl/bank_lock_arbiter.sv
module bank_lock_arbiter
    import bla_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BIW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic [BIW-1:0]   req_bank,
    output logic             grant,
    output logic             lockout
);

    logic [NBANK-1:0] g_vec;
    logic [NBANK-1:0] l_vec;
    logic             in_range;
    logic             retry;

    assign in_range = req_valid && ({{(32-BIW){1'b0}}, req_bank} < 32'(NBANK));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bla_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (in_range && (req_bank == BIW'(b))),
            .retry_i (retry),
            .src_i   (req_src),
            .grant_o (g_vec[b]),
            .lock_o  (l_vec[b])
        );
    end

    assign grant   = |g_vec;
    assign lockout = |l_vec;

    bla_retry #(.BIW(BIW)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (req_src),
        .bank_i  (req_bank),
        .grant_i (grant),
        .lock_i  (lockout),
        .retry_o (retry)
    );

    p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> (grant != lockout));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(grant || lockout));

    p_range_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> !(grant || lockout));

    p_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g_vec | l_vec));

endmodule

// File: tb/bank_lock_arbiter_bench.sv
`timescale 1ns/1ps
module bank_lock_arbiter_bench;

    localparam int NB  = 8;
    localparam int BIW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [1:0]     req_src = '0;
    logic [BIW-1:0] req_bank = '0;
    logic           grant;
    logic           lockout;

    int checks = 0;
    int errors = 0;
    int slot_no = 0;
    bit done = 1'b0;

    int m_cnt [NB];
    bit m_rv  [NB];
    int m_own [NB];
    int last_g[NB];
    bit m_pend[4];
    int m_pb  [4];

    always #4 clk = ~clk;

    bank_lock_arbiter #(.NBANK(NB), .BIW(BIW)) u_bank_lock_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_bank(req_bank), .grant(grant), .lockout(lockout)
    );

    function automatic int cls(int s);
        return (s == 0) ? 2 : ((s == 1) ? 1 : 0);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < NB; k++) begin
            m_cnt[k] = 0; m_rv[k] = 0; m_own[k] = 0; last_g[k] = -100;
        end
        for (int k = 0; k < 4; k++) begin
            m_pend[k] = 0; m_pb[k] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // use_model=1 takes expectations from the arithmetic model
    task automatic slot(bit v, int s, int b, bit use_model, bit eg, bit el, string tag);
        bit mg, ml, rt, xg, xl;
        @(negedge clk);
        req_valid = v; req_src = 2'(s); req_bank = BIW'(b);
        #1;
        mg = v && (b < NB) && (m_cnt[b % NB] == 0) &&
             (!m_rv[b % NB] || m_own[b % NB] == s);
        ml = v && (b < NB) && !mg;
        xg = use_model ? mg : eg;
        xl = use_model ? ml : el;
        checks++;
        if (grant !== xg || lockout !== xl) begin
            errors++;
            $display("FAIL %s slot %0d: grant=%0b lockout=%0b expected grant=%0b lockout=%0b",
                     tag, slot_no, grant, lockout, xg, xl);
        end
        if (grant === 1'b1 && b < NB) begin
            checks++;
            if (slot_no - last_g[b] < 8) begin
                errors++;
                $display("FAIL R1 slot %0d: bank %0d regranted after %0d slots, expected >= 8",
                         slot_no, b, slot_no - last_g[b]);
            end
            if (m_rv[b] && cls(s) < cls(m_own[b])) begin
                errors++;
                $display("FAIL R5 slot %0d: class %0d granted, expected lockout for owner class %0d",
                         slot_no, cls(s), cls(m_own[b]));
            end
            last_g[b] = slot_no;
        end
        rt = (b < NB) && m_pend[s] && m_pb[s] == b;
        for (int k = 0; k < NB; k++) if (m_cnt[k] > 0) m_cnt[k]--;
        if (mg) begin
            m_cnt[b] = 7;
            if (m_rv[b] && m_own[b] == s) m_rv[b] = 0;
            m_pend[s] = 0;
        end else if (ml) begin
            if (rt && cls(s) > 0 && (!m_rv[b] || cls(s) > cls(m_own[b]))) begin
                m_rv[b] = 1; m_own[b] = s;
            end
            m_pend[s] = 1; m_pb[s] = b;
        end
        slot_no++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) slot(0, 0, 0, 0, 0, 0, "R2_idle");
    endtask

    initial begin
        bit [15:0] lfsr;
        model_clear();
        do_reset();

        // R11, R9: every bank idle after reset, grants in consecutive slots
        for (int b = 0; b < NB; b++) slot(1, 3, b, 0, 1, 0, "R11_R9");
        slot(1, 0, 0, 0, 1, 0, "R1_R9");

        // R1: exact busy window edge
        do_reset();
        slot(1, 2, 3, 0, 1, 0, "R1");
        for (int i = 0; i < 7; i++) slot(1, 3, 3, 0, 0, 1, "R1_R2");
        slot(1, 3, 3, 0, 1, 0, "R1");

        // R4, R5, R6: processor reserves, computer turned away at idle bank
        do_reset();
        slot(1, 2, 1, 0, 1, 0, "R4");
        slot(1, 1, 1, 0, 0, 1, "R4");
        slot(1, 1, 1, 0, 0, 1, "R4");
        idle(5);
        slot(1, 3, 1, 0, 0, 1, "R5");
        slot(1, 1, 1, 0, 1, 0, "R6");
        slot(1, 3, 1, 0, 0, 1, "R6");
        idle(6);
        slot(1, 3, 1, 0, 1, 0, "R6");

        // R7: computers never reserve, first presenter wins
        do_reset();
        slot(1, 2, 2, 0, 1, 0, "R7");
        slot(1, 3, 2, 0, 0, 1, "R7");
        slot(1, 3, 2, 0, 0, 1, "R7");
        idle(5);
        slot(1, 2, 2, 0, 1, 0, "R7");

        // R8: I/O takes over a processor reservation, not the reverse
        do_reset();
        slot(1, 2, 4, 0, 1, 0, "R8");
        slot(1, 1, 4, 0, 0, 1, "R8");
        slot(1, 1, 4, 0, 0, 1, "R8");
        slot(1, 0, 4, 0, 0, 1, "R8");
        slot(1, 0, 4, 0, 0, 1, "R8");
        idle(3);
        slot(1, 1, 4, 0, 0, 1, "R8");
        slot(1, 0, 4, 0, 1, 0, "R8");

        // R11: reset drops busy state and reservations
        do_reset();
        slot(1, 3, 4, 0, 1, 0, "R11");

        // R10: out-of-range indices, including aliases of bank 1
        do_reset();
        slot(1, 2, 9, 0, 0, 0, "R10");
        slot(1, 0, 63, 0, 0, 0, "R10");
        slot(1, 1, 8, 0, 0, 0, "R10");
        slot(1, 3, 1, 0, 1, 0, "R10");
        slot(1, 3, 0, 0, 1, 0, "R10");

        // R2..R9: pseudo-random sweep over four banks against the model
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            int b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = (lfsr[7:5] == 3'd7) ? 9 : int'(lfsr[3:2]);
            slot(lfsr[0] | lfsr[8], int'(lfsr[11:10]), b, 1, 0, 0, "R3_sweep");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule